// File: doc/BRIEF.md
# Double-Rate Write Capture with Byte Masks

This block is the write half of a double-data-rate memory datapath, modelled on a single system clock. A write command supplies a starting word column and a burst-length code. The block then takes one data beat for each clock cycle in which the strobe-edge qualifier `beat_vld` is high. Beats alternate between the rising and the falling strobe edge, starting with a rising edge. Each beat carries a 16-bit data value and one mask bit per byte lane.

Every two beats are packed into one 32-bit word, which is committed to an internal word array. The rising-edge beat forms the lower half of the word and the falling-edge beat forms the upper half. Each byte is written only when its mask bit was low. Words within a burst land on consecutive columns that wrap inside a burst-sized aligned window. A one-cycle completion pulse follows each burst that runs to its end.

The array can be read combinationally through a read-address port. A new write command arriving mid-burst abandons the old burst and starts a fresh one. Reset clears the array.

Top module: `ddr_wcap`

## Requirements
- R1: After reset is applied and released, every array word reads 0 and `wr_done` is low.
- R2: Within a pair, the first beat (rising edge, even beat index) is stored in bits 15:0 of the word and the second beat (falling edge) in bits 31:16; a word is written only on the second beat of a pair.
- R3: `dm[0]` high blocks data bits 7:0 of its beat and `dm[1]` high blocks bits 15:8; a blocked byte keeps its previous array content.
- R4: `bl_sel` 0 selects 2 beats (1 word), 1 selects 4 beats (2 words), and 2 or 3 select 8 beats (4 words); no further words are written after the burst's last beat.
- R5: Word k of a burst (k = 0, 1, ...) is written to column (col AND NOT m) OR ((col + k) AND m), with m = 0, 1 or 3 for bursts of 2, 4 or 8 beats.
- R6: `wr_done` is high for exactly one cycle, during the second cycle after the clock edge that samples a burst's final beat.
- R7: `wr_cmd` during an active burst ends it: words already stored remain, an unpaired rising-edge beat is discarded, the abandoned burst gives no `wr_done`, and the new burst starts with a rising-edge beat at its own column.
- R8: `beat_vld` has no effect when no burst is active or in the same cycle as `wr_cmd`.
- R9: Cycles with `beat_vld` low inside a burst are idle gaps and do not change pairing or addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_cmd | input | 1 | Start a write burst this cycle |
| bl_sel | input | 2 | Burst length code: 0 = 2 beats, 1 = 4 beats, 2 or 3 = 8 beats |
| wr_col | input | 4 | Starting word column of the burst |
| beat_vld | input | 1 | A strobe edge occurs this cycle; `dq` and `dm` hold its beat |
| dq | input | 16 | Write data beat |
| dm | input | 2 | Per-lane mask for the beat; bit 0 covers bits 7:0, bit 1 covers bits 15:8 |
| rd_addr | input | 4 | Array word to observe |
| rd_data | output | 32 | Array word at `rd_addr` |
| wr_done | output | 1 | One-cycle pulse after a burst completes |

## Verification
The table drives bursts of every length code. The columns cover the aligned start, the unaligned start and the wrap-around case, so an address generator that carries out of its window or ignores the start offset writes to the wrong word. The mask patterns range from no masking through single-lane masking on chosen beats to fully masked bursts. These show whether each mask bit reaches its own lane and its own half-word, because every array word is compared after each burst. Bursts with idle gaps between beats separate a design that pairs on the beat parity from one that pairs on clock parity. Directed cases cover stray strobe edges outside a burst and in the command cycle, and a burst cut off after an unpaired beat. They also check the exact cycle of the completion pulse and the total number of pulses.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  typedef enum logic [1:0] {
    BLC_TWO   = 2'd0,
    BLC_FOUR  = 2'd1,
    BLC_EIGHT = 2'd2,
    BLC_EXTRA = 2'd3
  } blen_code_e;

  localparam int CNT_W = 4;

  // beats in a burst for a length code
  function automatic logic [CNT_W-1:0] beats_of(input logic [1:0] code);
    case (blen_code_e'(code))
      BLC_TWO:  return CNT_W'(2);
      BLC_FOUR: return CNT_W'(4);
      default:  return CNT_W'(8);
    endcase
  endfunction

  // low column bits that advance (and wrap) within a burst
  function automatic logic [2:0] wrap_of(input logic [1:0] code);
    case (blen_code_e'(code))
      BLC_TWO:  return 3'd0;
      BLC_FOUR: return 3'd1;
      default:  return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/ddrw_rst_sync.sv
module ddrw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ddrw_beat_ctl.sv
module ddrw_beat_ctl
  import ddrw_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [1:0]       bl_sel,
  input  logic [COL_W-1:0] col,
  input  logic             beat_vld,
  output logic             take,
  output logic             phase_hi,
  output logic             last_beat,
  output logic             busy,
  output logic [COL_W-1:0] waddr
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [1:0]       code_q, code_d;
  logic             ld_en;
  logic [COL_W-1:0] wmask;
  logic [COL_W-1:0] step;

  // beat acceptance and address generation
  always_comb begin
    take      = act_q & beat_vld & ~wr_cmd;
    phase_hi  = cnt_q[0];
    last_beat = take & (cnt_q == (beats_of(code_q) - 1'b1));
    wmask     = COL_W'(wrap_of(code_q));
    step      = COL_W'(cnt_q >> 1);
    waddr     = (base_q & ~wmask) | ((base_q + step) & wmask);
    busy      = act_q;
  end

  // next state
  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    code_d = code_q;
    ld_en  = wr_cmd | take;
    if (wr_cmd) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      base_d = col;
      code_d = bl_sel;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      act_d = ~last_beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      code_q <= '0;
    end else if (ld_en) begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
      code_q <= code_d;
    end
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < beats_of(code_q)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (act_q && (cnt_q == '0) && (base_q == $past(col))));

endmodule

// File: rtl/ddrw_pair_pack.sv
module ddrw_pair_pack #(
  parameter  int DQ_W  = 16,
  localparam int LANES = DQ_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 phase_hi,
  input  logic [DQ_W-1:0]      dq,
  input  logic [LANES-1:0]     dm,
  output logic                 we,
  output logic [2*DQ_W-1:0]    wdata,
  output logic [2*LANES-1:0]   wbe
);
  logic [DQ_W-1:0]  lo_q, lo_d;
  logic [LANES-1:0] lom_q, lom_d;
  logic             cap_en;

  always_comb begin
    cap_en = take & ~phase_hi;
    lo_d   = dq;
    lom_d  = dm;
    we     = take & phase_hi;
    wdata  = {dq, lo_q};
    wbe    = ~{dm, lom_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      lom_q <= '0;
    end else if (cap_en) begin
      lo_q  <= lo_d;
      lom_q <= lom_d;
    end
  end

  // R2
  no_b2b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

endmodule

// File: rtl/ddrw_wr_array.sv
module ddrw_wr_array #(
  parameter  int COL_W  = 4,
  parameter  int WORD_W = 32,
  localparam int NB     = WORD_W / 8,
  localparam int DEPTH  = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NB-1:0]     wbe,
  input  logic [COL_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] cell_q [DEPTH];
    logic       lane_en;

    always_comb lane_en = we & wbe[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
      end else if (lane_en) begin
        cell_q[waddr] <= wdata[g*8 +: 8];
      end
    end

    assign rd_data[g*8 +: 8] = cell_q[rd_addr];
  end
endmodule

// File: rtl/ddr_wcap.sv
module ddr_wcap
  import ddrw_pkg::*;
#(
  parameter  int DQ_W   = 16,
  parameter  int COL_W  = 4,
  localparam int LANES  = DQ_W / 8,
  localparam int WORD_W = 2 * DQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [1:0]        bl_sel,
  input  logic [COL_W-1:0]  wr_col,
  input  logic              beat_vld,
  input  logic [DQ_W-1:0]   dq,
  input  logic [LANES-1:0]  dm,
  input  logic [COL_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              wr_done
);
  logic               rst_ni;
  logic               take, phase_hi, last_beat, busy;
  logic [COL_W-1:0]   waddr;
  logic               mem_we;
  logic [WORD_W-1:0]  mem_wdata;
  logic [2*LANES-1:0] mem_wbe;
  logic               last_q, last_d;
  logic               done_q, done_d;

  ddrw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  ddrw_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_cmd    (wr_cmd),
    .bl_sel    (bl_sel),
    .col       (wr_col),
    .beat_vld  (beat_vld),
    .take      (take),
    .phase_hi  (phase_hi),
    .last_beat (last_beat),
    .busy      (busy),
    .waddr     (waddr)
  );

  ddrw_pair_pack #(.DQ_W(DQ_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_ni),
    .take     (take),
    .phase_hi (phase_hi),
    .dq       (dq),
    .dm       (dm),
    .we       (mem_we),
    .wdata    (mem_wdata),
    .wbe      (mem_wbe)
  );

  ddrw_wr_array #(.COL_W(COL_W), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_ni),
    .we      (mem_we),
    .waddr   (waddr),
    .wdata   (mem_wdata),
    .wbe     (mem_wbe),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // completion: flag the final store, pulse one cycle later
  always_comb begin
    last_d = last_beat;
    done_d = last_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  assign wr_done = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_done |=> !wr_done);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy ##1 $stable(rd_addr)) |-> $stable(rd_data));

endmodule

// File: tb/tb_ddr_wcap.sv
module tb_ddr_wcap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  localparam logic [1:0]   V_BL  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};
  localparam logic [3:0]   V_COL [NV] = '{4'd3, 4'd5, 4'd10, 4'd1, 4'd6, 4'd12};
  localparam logic [127:0] V_DQ  [NV] = '{
    128'h0000_0000_0000_0000_0000_0000_2B2A_1B1A,
    128'h0000_0000_0000_0000_4D4C_3D3C_2D2C_1D1C,
    128'h8E8F_7E7F_6E6F_5E5F_4E4F_3E3F_2E2F_1E1F,
    128'hF8F0_F7F0_F6F0_F5F0_F4F0_F3F0_F2F0_F1F0,
    128'h0000_0000_0000_0000_A4A4_A3A3_A2A2_A1A1,
    128'h1111_2222_3333_4444_5555_6666_7777_8888};
  localparam logic [15:0]  V_DM  [NV] = '{16'h0000, 16'h0024, 16'h4183,
                                          16'h0000, 16'h00F0, 16'hFFFF};
  localparam bit           V_GAP [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_cmd;
  logic [1:0]  bl_sel;
  logic [3:0]  wr_col;
  logic        beat_vld;
  logic [15:0] dq;
  logic [1:0]  dm;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic        wr_done;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int exp_pulses = 0;
  logic [31:0] exp_mem [16];

  ddr_wcap dut (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .bl_sel(bl_sel),
    .wr_col(wr_col), .beat_vld(beat_vld), .dq(dq), .dm(dm),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_done(wr_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && wr_done === 1'b1) pulses++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      chk(rd_data === exp_mem[a], req, $sformatf("word %0d", a), rd_data, exp_mem[a]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_cmd = 1'b0; beat_vld = 1'b0; bl_sel = '0; wr_col = '0;
    dq = '0; dm = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 16; a++) exp_mem[a] = '0;
  endtask

  // model of one stored pair, from R2, R3, R5
  task automatic model_pair(input logic [1:0] bl, input logic [3:0] col, input int k,
                            input logic [15:0] lo, input logic [15:0] hi,
                            input logic [1:0] ml, input logic [1:0] mh);
    logic [3:0] wm;
    logic [3:0] ad;
    wm = (bl == 2'd0) ? 4'd0 : (bl == 2'd1) ? 4'd1 : 4'd3;
    ad = (col & ~wm) | ((col + 4'(k)) & wm);
    if (!ml[0]) exp_mem[ad][7:0]   = lo[7:0];
    if (!ml[1]) exp_mem[ad][15:8]  = lo[15:8];
    if (!mh[0]) exp_mem[ad][23:16] = hi[7:0];
    if (!mh[1]) exp_mem[ad][31:24] = hi[15:8];
  endtask

  task automatic send_burst(input logic [1:0] bl, input logic [3:0] col,
                            input logic [127:0] d, input logic [15:0] m,
                            input int nsend, input bit gap, input bit junk,
                            input bit chk_done, input string req);
    @(negedge clk);
    wr_cmd = 1'b1; bl_sel = bl; wr_col = col;
    beat_vld = junk; dq = 16'hDEAD; dm = 2'b00;
    for (int i = 0; i < nsend; i++) begin
      @(negedge clk);
      wr_cmd = 1'b0;
      if (gap && i[0]) begin
        beat_vld = 1'b0;
        @(negedge clk);
      end
      beat_vld = 1'b1; dq = d[16*i +: 16]; dm = m[2*i +: 2];
      if (i[0])
        model_pair(bl, col, i/2, d[16*(i-1) +: 16], d[16*i +: 16],
                   m[2*(i-1) +: 2], m[2*i +: 2]);
    end
    @(negedge clk);
    wr_cmd = 1'b0; beat_vld = 1'b0;
    if (chk_done) begin
      exp_pulses++;
      chk(wr_done === 1'b0, "R6", "done one cycle after final beat", 32'(wr_done), 0);
      @(negedge clk);
      chk(wr_done === 1'b1, "R6", "done two cycles after final beat", 32'(wr_done), 1);
      @(negedge clk);
      chk(wr_done === 1'b0, "R6", "done pulse width", 32'(wr_done), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(wr_done === 1'b0, "R1", "wr_done after reset", 32'(wr_done), 0);
    check_mem("R1");

    // R8 stray strobe edges with no burst active
    @(negedge clk);
    beat_vld = 1'b1; dq = 16'hFFFF; dm = 2'b00;
    repeat (4) @(negedge clk);
    beat_vld = 1'b0;
    check_mem("R8 stray");

    // table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      send_burst(V_BL[v], V_COL[v], V_DQ[v], V_DM[v],
                 (V_BL[v] == 2'd0) ? 2 : (V_BL[v] == 2'd1) ? 4 : 8,
                 V_GAP[v], 1'b0, 1'b1, "R6");
      check_mem($sformatf("R2 R3 R4 R5 R9 vector %0d", v));
    end

    // R8 beat in the command cycle is ignored
    send_burst(2'd1, 4'd2, 128'h0000_0000_0000_0000_C4C4_C3C3_C2C2_C1C1,
               16'h0000, 4, 1'b0, 1'b1, 1'b1, "R6");
    check_mem("R8 command cycle");

    // R7 burst cut after an unpaired beat, then a fresh burst
    send_burst(2'd2, 4'd0, 128'h0000_0000_0000_0000_0000_E3E3_E2E2_E1E1,
               16'h0000, 3, 1'b0, 1'b0, 1'b0, "R7");
    send_burst(2'd0, 4'd15, 128'h0000_0000_0000_0000_0000_0000_F2F2_F1F1,
               16'h0000, 2, 1'b0, 1'b0, 1'b1, "R7");
    check_mem("R7 cut and restart");
    repeat (2) @(negedge clk);
    chk(pulses == exp_pulses, "R7", "completion pulse count", 32'(pulses), 32'(exp_pulses));

    // R1 reset after activity clears the array
    do_reset();
    chk(wr_done === 1'b0, "R1", "wr_done after second reset", 32'(wr_done), 0);
    check_mem("R1 second reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule